// File: doc/BRIEF.md
# UART Modem Line Status and Control

This block keeps the modem status byte of a 16550-style serial port and drives its two outgoing handshake pins. Four asynchronous modem inputs are synchronized: clear-to-send, data-set-ready, ring indicator and carrier detect. At defined sample moments they are copied into the high nibble of the status byte. At each sample the low nibble collects change flags. The flags stay set until software reads the byte. A modem-status interrupt request is raised while any flag is set and the interrupt enable is on.

The block also holds the 5-bit modem control value written by software. Outside loopback, a write that changes that value drives request-to-send and data-terminal-ready from it. The same write schedules one resample of the inputs a programmable character time later. With the modem-status interrupt enabled, the inputs are also resampled on a fixed poll period. Loopback suspends both the pin updates and all sampling. Interrupt priority encoding and the serial data paths belong to neighbouring blocks. All ports are plain control and status pins with no stream handshake.

Top module: `modem_status_unit`

## Requirements
- R1: The status byte's high nibble holds CTS in bit 4, DSR in bit 5, RI in bit 6 and DCD in bit 7. Each is the synchronized input as of the latest sample event, and the nibble does not change between sample events.
- R2: At a sample event, bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) are ORed with the XOR of the old and new values of their high bits. Once set, a change flag stays set until a read.
- R3: Bit 2 is set only when RI goes from 1 to 0 at a sample event, never when it rises.
- R4: A read pulse leaves `msr_q` unchanged in its own cycle and clears the four change flags at the next edge. A flag raised by a sample at that same edge stays set.
- R5: After reset the status byte is 0xB0, the control value is 0x08, both handshake pins are low and the interrupt request is low.
- R6: A control write stores bits 4:0 of the write data. Whenever loopback (control bit 4) is clear, `rts_out` equals control bit 1 and `dtr_out` equals control bit 0.
- R7: While control bit 4 is set, the handshake pins hold their values, including on the write that sets the bit, and no sample event occurs.
- R8: A control write that changes the value and has bit 4 clear causes one sample event exactly `char_ticks` clock edges after the write edge, with 0 treated as 1. A write of the current value causes none.
- R9: While `msi_en` is high and loopback is off, a sample event occurs every `POLL_CYCLES` clocks. While `msi_en` is low, there is no periodic sampling.
- R10: `msi_irq` is high exactly when `msi_en` is high and at least one of the four change flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| dsr_in | input | 1 | Asynchronous data-set-ready line |
| ri_in | input | 1 | Asynchronous ring indicator line |
| dcd_in | input | 1 | Asynchronous carrier detect line |
| msr_rd | input | 1 | One-cycle read strobe of the status byte |
| msr_q | output | 8 | Status byte: line states high, change flags low |
| mcr_wr | input | 1 | Control write strobe |
| mcr_wdata | input | 8 | Control write data; bits 7:5 ignored |
| mcr_q | output | 5 | Stored control value |
| msi_en | input | 1 | Modem-status interrupt enable; also turns on polling |
| char_ticks | input | CHAR_W | Character time in clocks for the post-write resample |
| rts_out | output | 1 | Request-to-send pin |
| dtr_out | output | 1 | Data-terminal-ready pin |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
On every cycle, the embedded properties check several behaviours. The high nibble holds still between sample events and while loopback is on. Change flags only accumulate until a read, and a plain read empties them. A ring flag only appears together with a falling RI bit. The handshake pins track the stored control bits whenever loopback is clear. Other behaviours need the bench's scenarios: the exact edge on which the post-write resample lands, the poll cadence, flag values for each particular sequence of line changes, and preservation of a flag raised on the same edge as a read.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int NLINES = 4;
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  localparam int MCR_W    = 5;
  localparam int MCR_DTR  = 0;
  localparam int MCR_RTS  = 1;
  localparam int MCR_LOOP = 4;

  typedef logic [NLINES-1:0] line_vec_t;
  typedef logic [MCR_W-1:0]  ctrl_t;

  localparam line_vec_t LINE_RST = 4'b1011;
  localparam ctrl_t     CTRL_RST = 5'h08;

  // change flags: XOR for level lines, falling edge only for the ring line
  function automatic line_vec_t delta_of(line_vec_t prev, line_vec_t cur);
    line_vec_t d;
    d        = prev ^ cur;
    d[L_RI]  = prev[L_RI] & ~cur[L_RI];
    return d;
  endfunction
endpackage

// File: rtl/msu_sync.sv
module msu_sync
  import msu_pkg::*;
#(
  parameter int        WIDTH = NLINES,
  parameter line_vec_t RSTV  = LINE_RST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RSTV[g];
        stab_q <= RSTV[g];
      end else begin
        meta_q <= async_in[g];
        stab_q <= meta_q;
      end
    end
    assign sync_out[g] = stab_q;
  end
endmodule

// File: rtl/msu_timers.sv
module msu_timers #(
  parameter int CHAR_W      = 16,
  parameter int POLL_CYCLES = 100000,
  localparam int PW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en,
  input  logic              loop,
  input  logic              settle_start,
  input  logic [CHAR_W-1:0] settle_len,
  output logic              sample
);
  logic [PW-1:0]     poll_cnt;
  logic [CHAR_W-1:0] settle_cnt;
  logic              poll_tick, settle_tick;

  assign poll_tick   = poll_en && (poll_cnt == PW'(POLL_CYCLES - 1));
  assign settle_tick = !settle_start && (settle_cnt == CHAR_W'(1));
  assign sample      = (poll_tick || settle_tick) && !loop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         poll_cnt <= '0;
    else if (!poll_en)  poll_cnt <= '0;
    else if (poll_tick) poll_cnt <= '0;
    else                poll_cnt <= poll_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                settle_cnt <= '0;
    else if (settle_start)     settle_cnt <= (settle_len == '0) ? CHAR_W'(1) : settle_len;
    else if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
  end

  // R9: with polling off, the poll counter stays parked at zero
  p_poll_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |=> (poll_cnt == '0));
endmodule

// File: rtl/msu_status.sv
module msu_status
  import msu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t line_s,
  input  logic      sample,
  input  logic      rd,
  input  logic      loop,
  output logic [7:0] msr
);
  line_vec_t up_q, dl_q, fresh;

  always_comb fresh = sample ? delta_of(up_q, line_s) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= LINE_RST;
      dl_q <= '0;
    end else begin
      if (sample) up_q <= line_s;
      dl_q <= (rd ? line_vec_t'('0) : dl_q) | fresh;
    end
  end

  assign msr = {up_q, dl_q};

  p_hold_between_samples_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(msr[7:4]));
  p_flags_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((msr[3:0] & $past(msr[3:0])) == $past(msr[3:0])));
  p_ring_falling_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr[2]) |-> $fell(msr[6]));
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !sample) |=> (msr[3:0] == 4'h0));
  p_loop_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop |=> $stable(msr[7:4]));
endmodule

// File: rtl/msu_ctrl.sv
module msu_ctrl
  import msu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ctrl_t      ctrl_q,
  output logic       rts,
  output logic       dtr,
  output logic       settle_start
);
  ctrl_t wv;
  logic  unused_hi;

  assign wv           = wdata[MCR_W-1:0];
  assign unused_hi    = ^wdata[7:MCR_W];
  assign settle_start = wr && !wv[MCR_LOOP] && (wv != ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      rts    <= CTRL_RST[MCR_RTS];
      dtr    <= CTRL_RST[MCR_DTR];
    end else begin
      if (wr) ctrl_q <= wv;
      if (settle_start) begin
        rts <= wv[MCR_RTS];
        dtr <= wv[MCR_DTR];
      end
    end
  end

  p_pins_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[MCR_LOOP] |-> (rts == ctrl_q[MCR_RTS]) && (dtr == ctrl_q[MCR_DTR]));
  p_loop_holds_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[MCR_LOOP]) |=> $stable(rts) && $stable(dtr));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msu_pkg::*;
#(
  parameter int CHAR_W      = 16,
  parameter int POLL_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              ri_in,
  input  logic              dcd_in,
  input  logic              msr_rd,
  output logic [7:0]        msr_q,
  input  logic              mcr_wr,
  input  logic [7:0]        mcr_wdata,
  output logic [4:0]        mcr_q,
  input  logic              msi_en,
  input  logic [CHAR_W-1:0] char_ticks,
  output logic              rts_out,
  output logic              dtr_out,
  output logic              msi_irq
);
  line_vec_t raw, line_s;
  ctrl_t     ctrl;
  logic      settle_start, sample, loop;

  always_comb begin
    raw        = '0;
    raw[L_CTS] = cts_in;
    raw[L_DSR] = dsr_in;
    raw[L_RI]  = ri_in;
    raw[L_DCD] = dcd_in;
  end

  assign loop  = ctrl[MCR_LOOP];
  assign mcr_q = ctrl;

  msu_sync #(.WIDTH(NLINES), .RSTV(LINE_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw), .sync_out(line_s));

  msu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(mcr_wr), .wdata(mcr_wdata),
    .ctrl_q(ctrl), .rts(rts_out), .dtr(dtr_out), .settle_start(settle_start));

  msu_timers #(.CHAR_W(CHAR_W), .POLL_CYCLES(POLL_CYCLES)) u_timers (
    .clk(clk), .rst_n(rst_n), .poll_en(msi_en && !loop), .loop(loop),
    .settle_start(settle_start), .settle_len(char_ticks), .sample(sample));

  msu_status u_status (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .sample(sample),
    .rd(msr_rd), .loop(loop), .msr(msr_q));

  assign msi_irq = msi_en && (msr_q[3:0] != 4'h0);

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en || msr_q[3:0] == 4'h0) |-> !msi_irq);
endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 16;
  localparam int POLL = 20;
  localparam int CT   = 8;
  // {line nibble {dcd,ri,dsr,cts}, expected status byte}
  localparam logic [11:0] VEC [8] = '{
    {4'hA, 8'hA1}, {4'hE, 8'hE0}, {4'hA, 8'hA4}, {4'h0, 8'h0A},
    {4'hF, 8'hFB}, {4'h0, 8'h0F}, {4'h0, 8'h00}, {4'h9, 8'h99}};

  logic clk = 0, rst_n = 0;
  logic cts_in, dsr_in, ri_in, dcd_in, msr_rd = 0, mcr_wr = 0, msi_en = 0;
  logic [7:0] mcr_wdata = 0, msr_q;
  logic [4:0] mcr_q;
  logic [CW-1:0] char_ticks = CW'(CT);
  logic rts_out, dtr_out, msi_irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_unit #(.CHAR_W(CW), .POLL_CYCLES(POLL)) i_modem_status_unit (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in),
    .dcd_in(dcd_in), .msr_rd(msr_rd), .msr_q(msr_q), .mcr_wr(mcr_wr),
    .mcr_wdata(mcr_wdata), .mcr_q(mcr_q), .msi_en(msi_en), .char_ticks(char_ticks),
    .rts_out(rts_out), .dtr_out(dtr_out), .msi_irq(msi_irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_lines(logic [3:0] v);
    {dcd_in, ri_in, dsr_in, cts_in} = v;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mcr(logic [7:0] v);
    mcr_wr = 1; mcr_wdata = v;
    @(negedge clk);
    mcr_wr = 0;
  endtask

  task automatic read_msr();
    msr_rd = 1;
    @(negedge clk);
    msr_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_lines(4'hB);
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R5 reset state
    chk("R5 msr", msr_q, 8'hB0);
    chk("R5 mcr", {3'b0, mcr_q}, 8'h08);
    chk("R5 pins", {6'b0, rts_out, dtr_out}, 8'h00);
    chk("R5 irq", {7'b0, msi_irq}, 8'h00);

    // vector table: each step resamples via a changing control write
    for (int i = 0; i < 8; i++) begin
      set_lines(VEC[i][11:8]);
      wait_n(4);
      write_mcr((i % 2 == 0) ? 8'h09 : 8'h08);
      wait_n(CT + 2);
      chk("R1/R2/R3 msr", msr_q, VEC[i][7:0]);
      chk("R6 dtr", {7'b0, dtr_out}, (i % 2 == 0) ? 8'h01 : 8'h00);
      chk("R10 irq off", {7'b0, msi_irq}, 8'h00);
      read_msr();
      chk("R4 cleared", msr_q, {VEC[i][11:8], 4'h0});
    end

    // R8: same-value write triggers no resample
    set_lines(4'h0);
    wait_n(4);
    write_mcr(8'h08);
    wait_n(CT + 4);
    chk("R8 no resample", msr_q, 8'h90);

    // R8: resample lands exactly CT edges after the write edge
    write_mcr(8'h0A);
    wait_n(CT - 1);
    chk("R8 before", msr_q, 8'h90);
    wait_n(1);
    chk("R8 at", msr_q, 8'h09);
    chk("R6 rts", {6'b0, rts_out, dtr_out}, 8'h02);
    read_msr();

    // R4: flag raised on the read edge survives
    set_lines(4'h1);
    wait_n(4);
    write_mcr(8'h0B);
    wait_n(CT + 2);
    chk("R2 pending", msr_q, 8'h11);
    set_lines(4'h9);
    wait_n(4);
    write_mcr(8'h0A);
    wait_n(CT - 1);
    msr_rd = 1;
    @(negedge clk);
    msr_rd = 0;
    chk("R4 coincide", msr_q, 8'h98);
    read_msr();

    // R9/R10 polling with interrupt enable
    set_lines(4'h8);
    wait_n(4);
    msi_en = 1;
    wait_n(POLL + 4);
    chk("R9 poll", msr_q, 8'h81);
    chk("R10 irq on", {7'b0, msi_irq}, 8'h01);
    read_msr();
    chk("R10 irq cleared", {7'b0, msi_irq}, 8'h00);
    msi_en = 0;
    set_lines(4'h0);
    wait_n(3 * POLL);
    chk("R9 no poll", msr_q, 8'h80);

    // R7 loopback: pins held, no sampling by poll or write
    write_mcr(8'h13);
    chk("R6 loop mcr", {3'b0, mcr_q}, 8'h13);
    chk("R7 pins held", {6'b0, rts_out, dtr_out}, 8'h02);
    msi_en = 1;
    wait_n(3 * POLL + CT);
    chk("R7 frozen", msr_q, 8'h80);
    write_mcr(8'h08);
    chk("R6 exit pins", {6'b0, rts_out, dtr_out}, 8'h00);
    wait_n(CT + 2);
    chk("R7 resumed", msr_q, 8'h08);
    chk("R10 irq", {7'b0, msi_irq}, 8'h01);
    msi_en = 0;

    // R6: upper write bits dropped
    write_mcr(8'hE5);
    chk("R6 width", {3'b0, mcr_q}, 8'h05);
    chk("R6 pins", {6'b0, rts_out, dtr_out}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule